// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapping

This block is the next-address engine of a microprogrammed control unit. A control address register selects one word of an internal control store. The selected microinstruction sits in a control data register, and its control-signal bits drive the datapath for one cycle. During that cycle the sequencer already works out which word comes next. The datapath itself lies outside the block.

The next word can come from one of four sources. It can be the following address. It can be the address field of the current word, taken always or only when a chosen status line is high. It can be the start of the routine for the current machine opcode. Or it can be a saved return address. Each opcode routine begins at the opcode times a fixed routine length of 8 words. That length is a power of two, so the mapped address is the opcode with three zero bits appended. Address 0 holds the fetch routine, and reset starts there.

The control store is a constant table computed by a package function. A fetch sequence runs through words 0..3 and ends in a mapping jump. Routines at 8·k (k = 1..7) test status lines, call a shared two-word subroutine at words 5..6, and return to fetch.

Top module: `useq_top`

## Requirements
- R1: While rst_ni is low, and from the moment it goes low, car_o is 0 and ctrl_o holds the control bits of word 0 (8'h01).
- R2: A word whose branch type is 0 (next) is followed, one clock later, by car_o equal to the current car_o plus one, modulo 64.
- R3: A word whose branch type is 1 (branch) loads its address field into car_o on the next clock when its condition is true. Condition select 0 means always true, and select s (1..3) means status_i[s-1].
- R4: A branch word whose selected condition is false is followed by car_o equal to the current car_o plus one.
- R5: A word whose branch type is 2 (map) is followed by car_o equal to opcode_i × 8, using the opcode present in that cycle.
- R6: Every taken branch saves its address plus one as the return address. A word whose branch type is 3 (return) is followed by car_o equal to the most recently saved return address, which is 0 after reset.
- R7: In every cycle, ctrl_o equals the control bits of the store word at address car_o. The word layout is control[17:10], condition select[9:8], branch type[7:6] and address[5:0].
- R8: opcode_i has no effect on car_o except in a map cycle. status_i has no effect except in a branch cycle whose condition select is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 3 | Machine opcode used by map words |
| status_i | input | 3 | Status lines tested by conditional branches |
| car_o | output | 6 | Control address register |
| ctrl_o | output | 8 | Control bits of the current microinstruction |

## Verification
The return path is the hardest case to reach from the ports. The fetch branch on status_i[0] must route through the map word with a nonzero opcode. The routine's first conditional branch on status_i[1] must then fail, so that the call word runs and saves a return address. The subroutine's return word then has to land back inside that routine. The bench drives opcode_i and status_i with fresh random values every cycle over several thousand cycles and a mid-run reset, so every branch outcome and every opcode routine is visited many times. A behavioural model predicts each address and control value.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W   = 6;
  localparam int OP_W     = 3;
  localparam int CTRL_W   = 8;
  localparam int CSEL_W   = 2;
  localparam int RLEN_LOG = ADDR_W - OP_W;          // routine length 2**RLEN_LOG
  localparam int STAT_W   = (1 << CSEL_W) - 1;

  typedef enum logic [1:0] {
    BT_NEXT   = 2'd0,
    BT_BRANCH = 2'd1,
    BT_MAP    = 2'd2,
    BT_RET    = 2'd3
  } btype_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [CSEL_W-1:0] csel;
    btype_e            bt;
    logic [ADDR_W-1:0] addr;
  } uinstr_t;

  localparam int UI_W = $bits(uinstr_t);

  function automatic uinstr_t mk(logic [CTRL_W-1:0] c, logic [CSEL_W-1:0] s,
                                 btype_e b, logic [ADDR_W-1:0] a);
    uinstr_t u;
    u.ctrl = c;
    u.csel = s;
    u.bt   = b;
    u.addr = a;
    return u;
  endfunction

  // Control store contents: fetch in routine 0, opcode k routine at k*2**RLEN_LOG
  function automatic uinstr_t ustore_word(logic [ADDR_W-1:0] a);
    logic [OP_W-1:0]     k;
    logic [RLEN_LOG-1:0] off;
    uinstr_t             u;
    k   = a[ADDR_W-1 -: OP_W];
    off = a[RLEN_LOG-1:0];
    if (k == '0) begin
      case (off)
        3'd0:    u = mk(8'h01, 2'd0, BT_NEXT,   6'd0);
        3'd1:    u = mk(8'h02, 2'd1, BT_BRANCH, 6'd3);
        3'd2:    u = mk(8'h04, 2'd0, BT_NEXT,   6'd0);
        3'd3:    u = mk(8'h08, 2'd0, BT_MAP,    6'd0);
        3'd5:    u = mk(8'h55, 2'd0, BT_NEXT,   6'd0);
        3'd6:    u = mk(8'h66, 2'd0, BT_RET,    6'd0);
        default: u = mk(8'h40, 2'd0, BT_BRANCH, 6'd0);
      endcase
    end else begin
      case (off)
        3'd0:    u = mk({4'hA, 1'b0, k}, 2'd2, BT_BRANCH, {k, 3'd4});
        3'd1:    u = mk({4'hB, 1'b0, k}, 2'd0, BT_BRANCH, 6'd5);
        3'd2:    u = mk({4'hC, 1'b0, k}, 2'd0, BT_BRANCH, 6'd0);
        3'd4:    u = mk({4'hD, 1'b0, k}, 2'd3, BT_BRANCH, 6'd0);
        3'd5:    u = mk({4'hE, 1'b0, k}, 2'd0, BT_BRANCH, 6'd0);
        default: u = mk(8'hF0, 2'd0, BT_BRANCH, 6'd0);
      endcase
    end
    return u;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output uinstr_t           word_o
);
  assign word_o = ustore_word(addr_i);
endmodule

// File: rtl/useq_branch.sv
module useq_branch
  import useq_pkg::*;
(
  input  uinstr_t           mi_i,
  input  logic [ADDR_W-1:0] car_i,
  input  logic [ADDR_W-1:0] ret_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              take_o
);
  logic [STAT_W:0] cond_vec;
  logic            cond;

  assign cond_vec = {status_i, 1'b1};   // select 0 is always true
  assign cond     = cond_vec[mi_i.csel];

  always_comb begin
    take_o = 1'b0;
    nxt_o  = car_i + 1'b1;
    unique case (mi_i.bt)
      BT_NEXT: ;
      BT_BRANCH: if (cond) begin
        take_o = 1'b1;
        nxt_o  = mi_i.addr;
      end
      BT_MAP:  nxt_o = {opcode_i, {RLEN_LOG{1'b0}}};
      BT_RET:  nxt_o = ret_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [ADDR_W-1:0] car_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [ADDR_W-1:0] car_q, ret_q, nxt;
  uinstr_t           cdr_q, rd_word;
  logic              take;

  useq_branch u_branch (
    .mi_i    (cdr_q),
    .car_i   (car_q),
    .ret_i   (ret_q),
    .opcode_i(opcode_i),
    .status_i(status_i),
    .nxt_o   (nxt),
    .take_o  (take)
  );

  // Read ahead with the next address so the data register tracks the address register
  useq_store u_store (
    .addr_i(nxt),
    .word_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= '0;
      cdr_q <= ustore_word('0);
      ret_q <= '0;
    end else begin
      car_q <= nxt;
      cdr_q <= rd_word;
      if (take) ret_q <= car_q + 1'b1;
    end
  end

  assign car_o  = car_q;
  assign ctrl_o = cdr_q.ctrl;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   opcode_i,
  input logic [STAT_W-1:0] status_i,
  input logic [ADDR_W-1:0] car_i,
  input logic [CTRL_W-1:0] ctrl_i
);
  uinstr_t w;
  logic    c_true;

  assign w      = ustore_word(car_i);
  assign c_true = (w.csel == '0) || status_i[w.csel - 2'd1];

  always_comb begin
    if (rst_ni) AST_CTRL_MATCH: assert (ctrl_i == w.ctrl); // R7
  end

  AST_RESET_ADDR: assert property (@(posedge clk_i) !rst_ni |-> car_i == '0); // R1
  AST_SEQ_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w.bt == BT_NEXT |=> car_i == $past(car_i) + 6'd1); // R2
  AST_BR_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w.bt == BT_BRANCH && c_true) |=> car_i == $past(w.addr)); // R3
  AST_BR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w.bt == BT_BRANCH && !c_true) |=> car_i == $past(car_i) + 6'd1); // R4
  AST_MAP_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w.bt == BT_MAP |=> car_i == {$past(opcode_i), 3'b000}); // R5
endmodule

bind useq_top useq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .opcode_i(opcode_i),
  .status_i(status_i),
  .car_i   (car_o),
  .ctrl_i  (ctrl_o)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
  import useq_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [OP_W-1:0]   opcode_i = '0;
  logic [STAT_W-1:0] status_i = '0;
  logic [ADDR_W-1:0] car_o;
  logic [CTRL_W-1:0] ctrl_o;

  int checks = 0;
  int errors = 0;
  int m_car, m_ret;
  string tag;
  int n_ret = 0, n_map = 0, n_taken = 0, n_fall = 0;

  always #4 clk_i = ~clk_i;

  useq_top dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive fresh inputs and advance the model by one clock
  task automatic step();
    uinstr_t w;
    bit      c;
    opcode_i = OP_W'($urandom);
    status_i = STAT_W'($urandom);
    w = ustore_word(ADDR_W'(m_car));
    case (w.bt)
      BT_NEXT: begin m_car = (m_car + 1) % 64; tag = "R2 R8"; end
      BT_BRANCH: begin
        c = (w.csel == 0) ? 1'b1 : status_i[int'(w.csel) - 1];
        if (c) begin
          m_ret = (m_car + 1) % 64; m_car = int'(w.addr); tag = "R3"; n_taken++;
        end else begin
          m_car = (m_car + 1) % 64; tag = "R4 R8"; n_fall++;
        end
      end
      BT_MAP: begin m_car = int'(opcode_i) * 8; tag = "R5"; n_map++; end
      default: begin m_car = m_ret; tag = "R6"; n_ret++; end
    endcase
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      step();
      @(negedge clk_i);
      check(tag, int'(car_o), m_car);
      check("R7", int'(ctrl_o), int'(ustore_word(ADDR_W'(m_car)).ctrl));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", int'(car_o), 0);
    check("R1", int'(ctrl_o), 8'h01);
    m_car = 0; m_ret = 0;
    step();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(tag, int'(car_o), m_car);
    run(3000);
    #2 rst_ni = 1'b0;
    #1;
    check("R1", int'(car_o), 0);
    check("R1", int'(ctrl_o), 8'h01);
    @(negedge clk_i);
    m_car = 0; m_ret = 0;
    step();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(tag, int'(car_o), m_car);
    run(3000);
    check("R6 coverage", int'(n_ret > 20 && n_map > 20 && n_taken > 20 && n_fall > 20), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule